// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the write side of a parallel NOR flash device whose commands are guarded by a multi-cycle unlock handshake. Every bus write cycle presents a byte address and a data word. The sequencer counts the unlock cycles and remembers the command that is pending. It applies program, sector-erase and chip-erase operations to a small internal storage array. It also tells the read path which view to present: plain array data, device identification, query table, or operation status.

Programming can only clear bits, because the written word is ANDed into the stored word. An erase sets a whole sector, or the whole array, back to all ones and then keeps the device busy for a fixed number of clock cycles. A bypass mode lets software program with two write cycles instead of four. The read path's own data formatting (status bits, ID and query contents) lies outside this block. Only the raw array contents and the mode selector are exported.

Top module: `nflseq_top`

## Requirements
- R1: A synchronous active-high reset puts the block in read mode (`mode` = 2'b00) with bypass off, and sets every stored word to all ones.
- R2: The low byte of `wr_data` is the command code. Unlock and command addresses are compared against the in-sector word offset, which is (byte address mod sector size) shifted right by log2 of the device width in bytes. The sector number and the byte-lane bits play no part in the match.
- R3: A sequence starts only when 0xAA is written to offset UNLOCK0 and is then followed by 0x55 at offset UNLOCK1. Any other write at either step returns the block to read mode.
- R4: The command cycle must target UNLOCK0, unless bypass is active. The command codes are as follows. 0x80 is erase setup. 0x90 is identification (`mode` = 2'b01). 0xA0 is program, which shows `mode` = 2'b11 while the data cycle is pending. 0x20 enters bypass. Any other code, or a wrong address, returns the block to read mode.
- R5: Writing 0xF0 returns the block to read mode and clears bypass from every state, with two exceptions: a program awaiting its data cycle (where the 0xF0 is stored as data) and a running erase.
- R6: Writing 0x98 at offset 0x55 in read mode or in identification mode selects the query view (`mode` = 2'b10). The next write of any kind returns the block to read mode and changes no stored data.
- R7: The program data cycle stores (old word AND written word) at the addressed word. The block then goes to read mode, or back to the command step if bypass is active.
- R8: The erase sequence is 0x80, then 0xAA at UNLOCK0, then 0x55 at UNLOCK1, then a final cycle. A final 0x10 at UNLOCK0 sets every word to all ones and shows `mode` = 2'b11 for CHIP_ERASE_CYC cycles. A final 0x10 at another offset returns the block to read mode with no erase.
- R9: A final 0x30 at any address sets every word of the sector holding that address to all ones, leaves all other sectors untouched, and shows `mode` = 2'b11 for SECTOR_ERASE_CYC cycles.
- R10: While an erase runs, every write is ignored, including 0xF0. When the erase ends, the block returns to read mode, or to the command step if bypass is active.
- R11: In bypass mode, 0xA0 followed by a data cycle programs with no unlock pair and no address check. Writing 0x90 and then 0x00 leaves bypass, after which a lone 0xA0 no longer starts a program.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W (10) | Byte address of the write cycle |
| wr_data | input | DATA_W (16) | Write data; the low byte doubles as command code |
| rd_addr | input | ADDR_W (10) | Byte address for the array read port |
| rd_data | output | DATA_W (16) | Stored word at `rd_addr` (combinational) |
| mode | output | 2 | Read view: 00 array, 01 identification, 10 query, 11 status |

## Verification
A wrong sequencer state shows up at `mode` on the cycle right after the write that caused it. A broken unlock count, in contrast, appears only later, when the command that follows is either ignored or wrongly accepted. The bench therefore follows every directed write with a probe of `mode`, plus a read of the affected words. A wrong erase sector, or an overwrite instead of an AND, shows in `rd_data` on the first cycle after the write. A busy counter that is off by one shows as a `mode` change one cycle early or late at the end of an erase, so the erase windows are checked at both edges.

// File: rtl/nflseq_pkg.sv
`timescale 1ns/1ps
package nflseq_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'b00,
        MODE_ID     = 2'b01,
        MODE_QUERY  = 2'b10,
        MODE_STATUS = 2'b11
    } rd_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLK2,
        ST_CMD,
        ST_PGM,
        ST_AUTOSEL,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_ERS_FINAL,
        ST_BUSY,
        ST_QUERY
    } seq_state_e;

    localparam logic [7:0] CODE_KEY_A    = 8'hAA;
    localparam logic [7:0] CODE_KEY_B    = 8'h55;
    localparam logic [7:0] CODE_ERS_SET  = 8'h80;
    localparam logic [7:0] CODE_IDENT    = 8'h90;
    localparam logic [7:0] CODE_PGM      = 8'hA0;
    localparam logic [7:0] CODE_BYP_ON   = 8'h20;
    localparam logic [7:0] CODE_BYP_OFF  = 8'h00;
    localparam logic [7:0] CODE_CHIP     = 8'h10;
    localparam logic [7:0] CODE_SECT     = 8'h30;
    localparam logic [7:0] CODE_ABORT    = 8'hF0;
    localparam logic [7:0] CODE_QUERY    = 8'h98;
    localparam int unsigned QUERY_OFS    = 32'h55;

endpackage

// File: rtl/nflseq_fsm.sv
`timescale 1ns/1ps
module nflseq_fsm
    import nflseq_pkg::*;
#(
    parameter int          SEC_OFS_W      = 7,
    parameter int unsigned UNLOCK0        = 32'h55,
    parameter int unsigned UNLOCK1        = 32'h2A,
    parameter int          SEC_ERASE_CYC  = 20,
    parameter int          CHIP_ERASE_CYC = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           wr_cmd,
    input  logic [SEC_OFS_W-1:0] wr_ofs,
    output rd_mode_e             mode_o,
    output logic                 prog_en,
    output logic                 sect_erase_en,
    output logic                 chip_erase_en
);

    localparam int MAX_ERASE = (CHIP_ERASE_CYC > SEC_ERASE_CYC) ? CHIP_ERASE_CYC : SEC_ERASE_CYC;
    localparam int CNT_W     = $clog2(MAX_ERASE + 1);

    typedef struct packed {
        seq_state_e       st;
        logic             byp;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic hit0, hit1, query_key;

    always_comb begin
        hit0      = (32'(wr_ofs) == UNLOCK0);
        hit1      = (32'(wr_ofs) == UNLOCK1);
        query_key = (32'(wr_ofs) == QUERY_OFS) && (wr_cmd == CODE_QUERY);

        r_d           = r_q;
        prog_en       = 1'b0;
        sect_erase_en = 1'b0;
        chip_erase_en = 1'b0;

        if (r_q.st == ST_BUSY) begin
            if (r_q.cnt <= CNT_W'(1)) begin
                r_d.st  = r_q.byp ? ST_CMD : ST_IDLE;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt - CNT_W'(1);
            end
        end else if (wr_en) begin
            if (wr_cmd == CODE_ABORT && r_q.st != ST_PGM) begin
                r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
            end else begin
                case (r_q.st)
                    ST_IDLE: begin
                        if (query_key)                        r_d.st = ST_QUERY;
                        else if (hit0 && wr_cmd == CODE_KEY_A) r_d.st = ST_UNLK2;
                        else r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                    end
                    ST_UNLK2: begin
                        if (hit1 && wr_cmd == CODE_KEY_B) r_d.st = ST_CMD;
                        else r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                    end
                    ST_CMD: begin
                        if (!r_q.byp && !hit0) begin
                            r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                        end else begin
                            case (wr_cmd)
                                CODE_BYP_ON:  r_d.byp = 1'b1;
                                CODE_ERS_SET: r_d.st  = ST_ERS_UNLK1;
                                CODE_IDENT:   r_d.st  = ST_AUTOSEL;
                                CODE_PGM:     r_d.st  = ST_PGM;
                                default:      r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                            endcase
                        end
                    end
                    ST_PGM: begin
                        prog_en = 1'b1;
                        r_d.st  = r_q.byp ? ST_CMD : ST_IDLE;
                    end
                    ST_AUTOSEL: begin
                        if (query_key && !(r_q.byp && wr_cmd == CODE_BYP_OFF)) r_d.st = ST_QUERY;
                        else r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                    end
                    ST_ERS_UNLK1: begin
                        if (hit0 && wr_cmd == CODE_KEY_A) r_d.st = ST_ERS_UNLK2;
                        else r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                    end
                    ST_ERS_UNLK2: begin
                        if (hit1 && wr_cmd == CODE_KEY_B) r_d.st = ST_ERS_FINAL;
                        else r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                    end
                    ST_ERS_FINAL: begin
                        if (wr_cmd == CODE_CHIP && hit0) begin
                            chip_erase_en = 1'b1;
                            r_d.st  = ST_BUSY;
                            r_d.cnt = CNT_W'(CHIP_ERASE_CYC);
                        end else if (wr_cmd == CODE_SECT) begin
                            sect_erase_en = 1'b1;
                            r_d.st  = ST_BUSY;
                            r_d.cnt = CNT_W'(SEC_ERASE_CYC);
                        end else begin
                            r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                        end
                    end
                    default: r_d = '{st: ST_IDLE, byp: 1'b0, cnt: '0};
                endcase
            end
        end

        case (r_q.st)
            ST_AUTOSEL:      mode_o = MODE_ID;
            ST_QUERY:        mode_o = MODE_QUERY;
            ST_PGM, ST_BUSY: mode_o = MODE_STATUS;
            default:         mode_o = MODE_ARRAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: ST_IDLE, byp: 1'b0, cnt: '0};
        else     r_q <= r_d;
    end

    // R10: an erase in progress is not shortened by any bus write
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_BUSY && r_q.cnt > CNT_W'(1)) |=>
        (r_q.st == ST_BUSY && r_q.cnt == $past(r_q.cnt) - CNT_W'(1)));

    // R6: query view lasts until the next write
    a_r6_query_leave: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_QUERY && wr_en) |=> (mode_o == MODE_ARRAY));

    // R5: abort code outside program-data and erase clears everything
    a_r5_abort: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cmd == CODE_ABORT && r_q.st != ST_PGM && r_q.st != ST_BUSY) |=>
        (r_q.st == ST_IDLE && !r_q.byp));

    // R7: the data cycle returns to read mode or the bypass command step
    a_r7_prog_return: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_PGM && wr_en) |=>
        (r_q.st == ($past(r_q.byp) ? ST_CMD : ST_IDLE)));

    // R3: a wrong second unlock cycle falls back to read mode
    a_r3_unlock_fail: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_UNLK2 && wr_en && wr_cmd != CODE_KEY_B) |=> (r_q.st == ST_IDLE));

endmodule

// File: rtl/nflseq_store.sv
`timescale 1ns/1ps
module nflseq_store #(
    parameter int DATA_W     = 16,
    parameter int WORD_IDX_W = 9,
    parameter int SEC_IDX_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_IDX_W-1:0] wr_word,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  prog_en,
    input  logic                  sect_erase_en,
    input  logic                  chip_erase_en,
    input  logic [WORD_IDX_W-1:0] rd_word,
    output logic [DATA_W-1:0]     rd_data
);

    localparam int WORDS = 1 << WORD_IDX_W;
    localparam int WPS_W = WORD_IDX_W - SEC_IDX_W;

    logic [DATA_W-1:0]    cell_q [WORDS];
    logic [SEC_IDX_W-1:0] wr_sec;

    assign wr_sec = wr_word[WORD_IDX_W-1 -: SEC_IDX_W];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [SEC_IDX_W-1:0]  MY_SEC  = SEC_IDX_W'(g >> WPS_W);
        localparam logic [WORD_IDX_W-1:0] MY_WORD = WORD_IDX_W'(g);
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (chip_erase_en || (sect_erase_en && wr_sec == MY_SEC))
                word_d = '1;
            else if (prog_en && wr_word == MY_WORD)
                word_d = word_q & wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst) word_q <= '1;
            else     word_q <= word_d;
        end

        assign cell_q[g] = word_q;
    end

    assign rd_data = cell_q[rd_word];

    // R7: programming merges by AND, never sets a bit
    a_r7_and_only: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> cell_q[$past(wr_word)] == ($past(cell_q[wr_word]) & $past(wr_data)));

    // R9: first word of the erased sector reads blank afterwards
    a_r9_sector_blank: assert property (@(posedge clk) disable iff (rst)
        sect_erase_en |=> cell_q[{$past(wr_sec), {WPS_W{1'b0}}}] == {DATA_W{1'b1}});

endmodule

// File: rtl/nflseq_top.sv
`timescale 1ns/1ps
module nflseq_top
    import nflseq_pkg::*;
#(
    parameter int          NUM_SECTORS    = 4,
    parameter int          SECTOR_BYTES   = 256,
    parameter int          DEV_BYTES      = 2,
    parameter int unsigned UNLOCK0        = 32'h55,
    parameter int unsigned UNLOCK1        = 32'h2A,
    parameter int          SEC_ERASE_CYC  = 20,
    parameter int          CHIP_ERASE_CYC = 40,
    localparam int         DATA_W         = 8 * DEV_BYTES,
    localparam int         ADDR_W         = $clog2(NUM_SECTORS * SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mode
);

    localparam int SHIFT      = $clog2(DEV_BYTES);
    localparam int SEC_BYTE_W = $clog2(SECTOR_BYTES);
    localparam int SEC_OFS_W  = SEC_BYTE_W - SHIFT;
    localparam int SEC_IDX_W  = $clog2(NUM_SECTORS);
    localparam int WORD_IDX_W = ADDR_W - SHIFT;

    logic [WORD_IDX_W-1:0] wr_word, rd_word;
    logic [SEC_OFS_W-1:0]  wr_ofs;
    logic                  prog_en, sect_erase_en, chip_erase_en;
    rd_mode_e              mode_e;
    logic                  unused_addr_bits;

    assign wr_word          = WORD_IDX_W'(wr_addr >> SHIFT);
    assign rd_word          = WORD_IDX_W'(rd_addr >> SHIFT);
    assign wr_ofs           = SEC_OFS_W'(wr_addr[SEC_BYTE_W-1:0] >> SHIFT);
    assign unused_addr_bits = ^{wr_addr, rd_addr};
    assign mode             = mode_e;

    nflseq_fsm #(
        .SEC_OFS_W      (SEC_OFS_W),
        .UNLOCK0        (UNLOCK0),
        .UNLOCK1        (UNLOCK1),
        .SEC_ERASE_CYC  (SEC_ERASE_CYC),
        .CHIP_ERASE_CYC (CHIP_ERASE_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_cmd        (wr_data[7:0]),
        .wr_ofs        (wr_ofs),
        .mode_o        (mode_e),
        .prog_en       (prog_en),
        .sect_erase_en (sect_erase_en),
        .chip_erase_en (chip_erase_en)
    );

    nflseq_store #(
        .DATA_W     (DATA_W),
        .WORD_IDX_W (WORD_IDX_W),
        .SEC_IDX_W  (SEC_IDX_W)
    ) u_store (
        .clk           (clk),
        .rst           (rst),
        .wr_word       (wr_word),
        .wr_data       (wr_data),
        .prog_en       (prog_en),
        .sect_erase_en (sect_erase_en),
        .chip_erase_en (chip_erase_en),
        .rd_word       (rd_word),
        .rd_data       (rd_data)
    );

endmodule

// File: tb/nflseq_top_test.sv
`timescale 1ns/1ps
module nflseq_top_test;

    localparam int U0 = 'h55;
    localparam int U1 = 'h2A;
    localparam int SEC_CYC  = 20;
    localparam int CHIP_CYC = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [9:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  mode;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench model: 0 idle,1 unlk2,2 cmd,3 pgm,4 ident,5 eu1,6 eu2,7 efinal,8 busy,9 query
    logic [15:0] mm [512];
    int  ms = 0;
    bit  mbyp = 0;
    int  mcnt = 0;

    always #10 clk = ~clk;

    nflseq_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode)
    );

    function automatic int ba(int sec, int wofs);
        return sec * 256 + wofs * 2;
    endfunction

    function automatic void m_abort();
        ms = 0; mbyp = 0; mcnt = 0;
    endfunction

    function automatic void model_step(bit we, int addr, logic [15:0] d);
        int ofs, word, sec;
        logic [7:0] c;
        bit h0, h1, qk;
        ofs = (addr % 256) >> 1; word = (addr >> 1) & 511; sec = (addr / 256) & 3;
        c = d[7:0]; h0 = (ofs == U0); h1 = (ofs == U1); qk = (ofs == 'h55) && (c == 8'h98);
        if (ms == 8) begin
            if (mcnt <= 1) begin ms = mbyp ? 2 : 0; mcnt = 0; end
            else mcnt--;
            return;
        end
        if (!we) return;
        if (c == 8'hF0 && ms != 3) begin m_abort(); return; end
        case (ms)
            0: if (qk) ms = 9; else if (h0 && c == 8'hAA) ms = 1; else m_abort();
            1: if (h1 && c == 8'h55) ms = 2; else m_abort();
            2: if (!mbyp && !h0) m_abort();
               else if (c == 8'h20) mbyp = 1;
               else if (c == 8'h80) ms = 5;
               else if (c == 8'h90) ms = 4;
               else if (c == 8'hA0) ms = 3;
               else m_abort();
            3: begin mm[word] = mm[word] & d; ms = mbyp ? 2 : 0; end
            4: if (mbyp && c == 8'h00) m_abort(); else if (qk) ms = 9; else m_abort();
            5: if (h0 && c == 8'hAA) ms = 6; else m_abort();
            6: if (h1 && c == 8'h55) ms = 7; else m_abort();
            7: if (c == 8'h10 && h0) begin
                   for (int i = 0; i < 512; i++) mm[i] = 16'hFFFF;
                   ms = 8; mcnt = CHIP_CYC;
               end else if (c == 8'h30) begin
                   for (int i = 0; i < 128; i++) mm[sec * 128 + i] = 16'hFFFF;
                   ms = 8; mcnt = SEC_CYC;
               end else m_abort();
            default: m_abort();
        endcase
    endfunction

    function automatic logic [1:0] exp_mode();
        case (ms)
            4: return 2'b01;
            9: return 2'b10;
            3, 8: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic cyc(input bit we, input int addr, input logic [15:0] d);
        wr_en = we; wr_addr = addr[9:0]; wr_data = d;
        @(posedge clk);
        model_step(we, addr, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [15:0] d);
        cyc(1'b1, addr, d);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 0, 16'h0);
    endtask

    task automatic unlock(input int sec);
        wr(ba(sec, U0), 16'h00AA);
        wr(ba(sec, U1), 16'h0055);
    endtask

    task automatic chk_mode(input logic [1:0] exp, input string tag);
        nchk++;
        if (mode !== exp) begin
            nfail++;
            $display("FAIL %s mode act=%b exp=%b at %0t", tag, mode, exp, $time);
        end
    endtask

    task automatic chk_word(input int w, input logic [15:0] exp, input string tag);
        rd_addr = 10'(w * 2);
        #1;
        nchk++;
        if (rd_data !== exp) begin
            nfail++;
            $display("FAIL %s word %0d act=%h exp=%h at %0t", tag, w, rd_data, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        bit ok;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) mm[i] = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_mode(2'b00, "R1");
        chk_word(0, 16'hFFFF, "R1");
        chk_word(300, 16'hFFFF, "R1");
        chk_word(511, 16'hFFFF, "R1");

        // R4 / R7 program
        unlock(0); wr(ba(0, U0), 16'h00A0);
        chk_mode(2'b11, "R4");
        wr(ba(0, 5), 16'h1234);
        chk_mode(2'b00, "R7");
        chk_word(5, 16'h1234, "R7");
        unlock(0); wr(ba(0, U0), 16'h00A0); wr(ba(0, 5), 16'hFF0F);
        chk_word(5, 16'h1204, "R7");

        // R5 abort code is data during program
        unlock(0); wr(ba(0, U0), 16'h00A0); wr(ba(0, 6), 16'h00F0);
        chk_word(6, 16'h00F0, "R5");
        chk_mode(2'b00, "R5");

        // R4 ident, R6 query
        unlock(0); wr(ba(0, U0), 16'h0090);
        chk_mode(2'b01, "R4");
        wr(ba(0, 'h55), 16'h0098);
        chk_mode(2'b10, "R6");
        wr(ba(0, 3), 16'h1111);
        chk_mode(2'b00, "R6");
        chk_word(3, 16'hFFFF, "R6");
        wr(ba(1, 'h55), 16'h0098);
        chk_mode(2'b10, "R6");
        wr(ba(1, 0), 16'h00F0);
        chk_mode(2'b00, "R6");

        // R5 abort from ident and mid-unlock
        unlock(0); wr(ba(0, U0), 16'h0090); wr(ba(0, 0), 16'h00F0);
        chk_mode(2'b00, "R5");
        wr(ba(0, U0), 16'h00AA); wr(ba(0, 0), 16'h00F0);
        wr(ba(0, U1), 16'h0055); wr(ba(0, U0), 16'h0090);
        chk_mode(2'b00, "R5");

        // R4 bad code and wrong address
        unlock(0); wr(ba(0, U0), 16'h0077); wr(ba(0, 9), 16'h0000);
        chk_mode(2'b00, "R4");
        chk_word(9, 16'hFFFF, "R4");
        unlock(0); wr(ba(0, U0 + 1), 16'h00A0);
        chk_mode(2'b00, "R4");

        // R3 broken unlock pair
        wr(ba(0, U0), 16'h00AA); wr(ba(0, U1 + 1), 16'h0055); wr(ba(0, U0), 16'h0090);
        chk_mode(2'b00, "R3");
        wr(ba(0, U0), 16'h00AB); wr(ba(0, U1), 16'h0055); wr(ba(0, U0), 16'h0090);
        chk_mode(2'b00, "R3");

        // R2 address scaling: sector and lane bits ignored, byte offset not used raw
        wr(ba(3, U0) + 1, 16'h00AA); wr(ba(2, U1), 16'h0055); wr(ba(1, U0), 16'h0090);
        chk_mode(2'b01, "R2");
        wr(0, 16'h00F0);
        wr(U0, 16'h00AA); wr(ba(0, U1), 16'h0055); wr(ba(0, U0), 16'h0090);
        chk_mode(2'b00, "R2");

        // R9 / R10 sector erase
        unlock(0); wr(ba(0, U0), 16'h00A0); wr(ba(1, 4), 16'h0000);
        unlock(0); wr(ba(0, U0), 16'h00A0); wr(ba(2, 7), 16'h00AA);
        unlock(0); wr(ba(0, U0), 16'h0080); unlock(0); wr(ba(1, 20), 16'h0030);
        chk_mode(2'b11, "R9");
        wr(ba(2, 7), 16'h00F0);
        chk_mode(2'b11, "R10");
        wr(ba(0, U0), 16'h00AA);
        chk_mode(2'b11, "R10");
        idle(SEC_CYC - 3);
        chk_mode(2'b11, "R9");
        idle(1);
        chk_mode(2'b00, "R9");
        chk_word(128 + 4, 16'hFFFF, "R9");
        chk_word(256 + 7, 16'h00AA, "R9");
        chk_word(5, 16'h1204, "R9");

        // R8 chip erase
        unlock(0); wr(ba(0, U0), 16'h0080); unlock(0); wr(ba(0, U1), 16'h0010);
        chk_mode(2'b00, "R8");
        chk_word(5, 16'h1204, "R8");
        unlock(0); wr(ba(0, U0), 16'h0080); unlock(0); wr(ba(2, U0), 16'h0010);
        chk_mode(2'b11, "R8");
        idle(CHIP_CYC - 1);
        chk_mode(2'b11, "R8");
        idle(1);
        chk_mode(2'b00, "R8");
        ok = 1;
        for (int i = 0; i < 512; i++) begin
            rd_addr = 10'(i * 2); #1;
            if (rd_data !== 16'hFFFF) ok = 0;
        end
        nchk++;
        if (!ok) begin nfail++; $display("FAIL R8 array not blank act=0 exp=1"); end

        // R11 bypass programming
        unlock(0); wr(ba(0, U0), 16'h0020);
        chk_mode(2'b00, "R11");
        wr(ba(1, 50), 16'h00A0);
        chk_mode(2'b11, "R11");
        wr(ba(1, 50), 16'h5A5A);
        chk_mode(2'b00, "R11");
        chk_word(128 + 50, 16'h5A5A, "R11");
        wr(ba(3, 1), 16'h00A0); wr(ba(3, 1), 16'h0F0F);
        chk_word(384 + 1, 16'h0F0F, "R11");

        // R10 erase inside bypass returns to bypass command step
        wr(ba(2, 9), 16'h0080); unlock(0); wr(ba(3, 0), 16'h0030);
        idle(SEC_CYC);
        chk_mode(2'b00, "R10");
        chk_word(384 + 1, 16'hFFFF, "R9");
        wr(ba(0, 2), 16'h00A0);
        chk_mode(2'b11, "R10");
        wr(ba(0, 2), 16'h1357);
        chk_word(2, 16'h1357, "R11");

        // R11 exit bypass with 0x90 then 0x00
        wr(ba(0, 70), 16'h0090);
        chk_mode(2'b01, "R11");
        wr(ba(0, 70), 16'h0000);
        chk_mode(2'b00, "R11");
        wr(ba(0, 8), 16'h00A0);
        chk_mode(2'b00, "R11");
        wr(ba(0, 8), 16'h0000);
        chk_word(8, 16'hFFFF, "R11");

        // R5 abort clears bypass
        unlock(0); wr(ba(0, U0), 16'h0020); wr(ba(0, 0), 16'h00F0); wr(ba(0, 1), 16'h00A0);
        chk_mode(2'b00, "R5");

        // random phase against bench model
        for (int i = 0; i < 4000; i++) begin
            int sel, ofs, addr;
            logic [7:0] code;
            bit we;
            we = ($urandom_range(0, 7) != 0);
            sel = $urandom_range(0, 5);
            ofs = (sel < 2) ? U0 : (sel < 4) ? U1 : (sel == 4) ? 'h55 : $urandom_range(0, 127);
            addr = $urandom_range(0, 3) * 256 + ofs * 2 + $urandom_range(0, 1);
            case ($urandom_range(0, 11))
                0, 1: code = 8'hAA;
                2, 3: code = 8'h55;
                4:  code = 8'h80;
                5:  code = 8'h90;
                6:  code = 8'hA0;
                7:  code = 8'h20;
                8:  code = ($urandom_range(0, 3) == 0) ? 8'h10 : 8'h30;
                9:  code = ($urandom_range(0, 2) == 0) ? 8'hF0 : 8'h00;
                10: code = 8'h98;
                default: code = 8'($urandom);
            endcase
            cyc(we, addr, {8'($urandom), code});
            chk_mode(exp_mode(), "R4");
            begin
                int w;
                w = $urandom_range(0, 511);
                chk_word(w, mm[w], "R7");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule